// File: doc/BRIEF.md
# Host Pixel Stream Port with Monochrome Expansion

This block lets the host supply the source pixels of a blit directly, instead of the blitter fetching them from pixel memory. Once a host-sourced copy has been started, the host writes 32-bit words into the port one after another. The port splits each word into pixels and presents them one at a time on a valid/ready stream to the rectangle walker. The walker handles address generation and memory writes and is not part of this block.

In colour mode each word holds packed pixels at the destination depth. In monochrome mode each bit selects one of two latched colours, foreground or background, so a one-bit glyph stream becomes full-depth pixels. The port also counts words. It holds off the end of the command until the full expected number of words has arrived. Words written while no command is running are swallowed and reported as an overrun.

Top module: `hostdata_port`

## Requirements
- R1: A pulse on `cmd_start_i` while idle, with `cmd_host_src_i`=1 and `cmd_fill_i`=0, starts a command on the next edge. `busy_o` is then high until every expected word has been accepted and every pixel has been handed over.
- R2: A start with `cmd_fill_i`=1 or `cmd_host_src_i`=0 leaves the port idle: `busy_o` stays low and no pixel appears.
- R3: A command accepts exactly ceil(W*H*B/4) words, where W=`width_m1_i`+1 and H=`height_m1_i`+1. B is 1 in monochrome mode. Otherwise B is 1, 2 or 4 for `depth_sel_i` 0, 1 and 2; the value 3 is treated as 4 bytes.
- R4: Colour mode emits W*H pixels, packed continuously across rows. Pixel k is lane k mod P of word k/P, where P=4/B and lane 0 is the least significant. Each pixel is zero-extended to 32 bits.
- R5: Monochrome mode (`cmd_mono_i`=1) emits W*H pixels. Pixel k comes from bit 7-(k mod 8) of byte (k mod 32)/8 of word k/32, with byte 0 the least significant. A 1 gives the foreground colour and a 0 gives the background colour, both masked to the destination depth (8, 16 or 32 bits).
- R6: In monochrome mode, words beyond the first ceil(W*H/32) are accepted up to the R3 count and produce no pixels.
- R7: While idle, `hw_ready_o` is high. A word written while idle is discarded, and `overrun_o` pulses for exactly one cycle on the following edge.
- R8: A start pulse while busy is ignored. The running command keeps its size and data.
- R9: Under backpressure, `pix_valid_o` and `pix_data_o` hold steady. `pix_last_o` marks only the final pixel of a command.
- R10: After reset the port is idle: `busy_o`, `pix_valid_o` and `overrun_o` are low and `hw_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_start_i | input | 1 | Command start pulse |
| cmd_host_src_i | input | 1 | Command bit 6: source data comes from the host |
| cmd_mono_i | input | 1 | Command bit 1: monochrome source |
| cmd_fill_i | input | 1 | Command bit 13: fill operation (no source) |
| depth_sel_i | input | 2 | Destination depth: 0=8, 1=16, 2/3=32 bits |
| width_m1_i | input | COORD_W | Rectangle width minus one |
| height_m1_i | input | COORD_W | Rectangle height minus one |
| fg_color_i | input | 32 | Foreground colour, latched at start |
| bg_color_i | input | 32 | Background colour, latched at start |
| hw_valid_i | input | 1 | Host word valid |
| hw_data_i | input | 32 | Host word |
| hw_ready_o | output | 1 | Port accepts the host word |
| pix_valid_o | output | 1 | Pixel valid |
| pix_data_o | output | 32 | Pixel value |
| pix_last_o | output | 1 | Final pixel of the command |
| pix_ready_i | input | 1 | Walker accepts the pixel |
| busy_o | output | 1 | Command in progress |
| overrun_o | output | 1 | One-cycle pulse: word discarded while idle |

## Verification
The hardest situation to reach is the accept decision in the cycle where the last pixel of a word leaves. In that same cycle a new host word may arrive, and it may come after the final pixel of the command, so it must be counted but dropped. Random gaps on both the host side and the walker side, over many small rectangles with odd sizes and all depths, make these collisions frequent. Monochrome cases with a long padding tail bring about the drop path. A word sent after every command shows that the count was exact, because it must then raise an overrun.

// File: rtl/hdp_pkg.sv
package hdp_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SUB_W  = 5;   // log2 of pixels per word in mono mode

  function automatic logic [1:0] depth_lg(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] depth_mask(input logic [1:0] lg);
    case (lg)
      2'd0:    return DATA_W'(32'h0000_00FF);
      2'd1:    return DATA_W'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/hdp_cmd_decode.sv
module hdp_cmd_decode
  import hdp_pkg::*;
#(
  parameter int unsigned COORD_W = 12,
  parameter int unsigned CNT_W   = 2*COORD_W + 4
) (
  input  logic               host_src_i,
  input  logic               mono_i,
  input  logic               fill_i,
  input  logic [1:0]         depth_sel_i,
  input  logic [COORD_W-1:0] width_m1_i,
  input  logic [COORD_W-1:0] height_m1_i,
  output logic               go_o,
  output logic [1:0]         lg_o,
  output logic [SUB_W-1:0]   per_word_m1_o,
  output logic [CNT_W-1:0]   words_o,
  output logic [CNT_W-1:0]   pix_o
);
  logic [CNT_W-1:0] w_ext, h_ext, prod, bytes_n;

  assign go_o  = host_src_i & ~fill_i;
  assign lg_o  = depth_lg(depth_sel_i);
  assign w_ext = CNT_W'(width_m1_i) + CNT_W'(1);
  assign h_ext = CNT_W'(height_m1_i) + CNT_W'(1);
  assign prod  = w_ext * h_ext;
  assign pix_o = prod;

  // mono counts one byte per pixel for the word budget
  assign bytes_n = prod << (mono_i ? 2'd0 : lg_o);
  assign words_o = (bytes_n + CNT_W'(3)) >> 2;

  always_comb begin
    if (mono_i) per_word_m1_o = SUB_W'(31);
    else case (lg_o)
      2'd0:    per_word_m1_o = SUB_W'(3);
      2'd1:    per_word_m1_o = SUB_W'(1);
      default: per_word_m1_o = SUB_W'(0);
    endcase
  end
endmodule

// File: rtl/hdp_counters.sv
module hdp_counters #(
  parameter int unsigned CNT_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] words_i,
  input  logic [CNT_W-1:0] pix_i,
  input  logic             word_take_i,
  input  logic             pix_fire_i,
  output logic             words_pend_o,
  output logic             pix_pend_o,
  output logic             pix_one_o,
  output logic             busy_o
);
  logic [CNT_W-1:0] words_left_q, pix_left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      words_left_q <= '0;
      pix_left_q   <= '0;
    end else if (load_i) begin
      words_left_q <= words_i;
      pix_left_q   <= pix_i;
    end else begin
      if (word_take_i) words_left_q <= words_left_q - CNT_W'(1);
      if (pix_fire_i)  pix_left_q   <= pix_left_q - CNT_W'(1);
    end
  end

  assign words_pend_o = |words_left_q;
  assign pix_pend_o   = |pix_left_q;
  assign pix_one_o    = (pix_left_q == CNT_W'(1));
  assign busy_o       = words_pend_o | pix_pend_o;
endmodule

// File: rtl/hdp_unpack.sv
module hdp_unpack
  import hdp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              mono_i,
  input  logic [1:0]        lg_i,
  input  logic [SUB_W-1:0]  per_word_m1_i,
  input  logic [DATA_W-1:0] fg_i,
  input  logic [DATA_W-1:0] bg_i,
  input  logic              last_pix_i,
  input  logic              pix_ready_i,
  output logic              pix_valid_o,
  output logic [DATA_W-1:0] pix_data_o,
  output logic              free_o
);
  logic [DATA_W-1:0] hold_q;
  logic              vld_q;
  logic [SUB_W-1:0]  sub_q;
  logic              fire;
  logic [4:0]        sh;
  logic [DATA_W-1:0] lane;
  logic [SUB_W-1:0]  bit_pos;

  assign fire   = vld_q & pix_ready_i;
  assign free_o = fire & ((sub_q == per_word_m1_i) | last_pix_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      vld_q  <= 1'b0;
      sub_q  <= '0;
    end else if (load_i) begin
      hold_q <= word_i;
      vld_q  <= 1'b1;
      sub_q  <= '0;
    end else if (fire) begin
      sub_q <= sub_q + SUB_W'(1);
      if (free_o) vld_q <= 1'b0;
    end
  end

  always_comb begin
    case (lg_i)
      2'd0:    sh = {sub_q[1:0], 3'b000};
      2'd1:    sh = {sub_q[0], 4'b0000};
      default: sh = 5'd0;
    endcase
  end

  // msb-first within each byte, bytes from the low end
  assign bit_pos = {sub_q[4:3], ~sub_q[2:0]};
  assign lane    = hold_q >> sh;

  assign pix_valid_o = vld_q;
  assign pix_data_o  = depth_mask(lg_i) &
                       (mono_i ? (hold_q[bit_pos] ? fg_i : bg_i) : lane);
endmodule

// File: rtl/hostdata_port.sv
module hostdata_port
  import hdp_pkg::*;
#(
  parameter int unsigned COORD_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_start_i,
  input  logic               cmd_host_src_i,
  input  logic               cmd_mono_i,
  input  logic               cmd_fill_i,
  input  logic [1:0]         depth_sel_i,
  input  logic [COORD_W-1:0] width_m1_i,
  input  logic [COORD_W-1:0] height_m1_i,
  input  logic [31:0]        fg_color_i,
  input  logic [31:0]        bg_color_i,
  input  logic               hw_valid_i,
  input  logic [31:0]        hw_data_i,
  output logic               hw_ready_o,
  output logic               pix_valid_o,
  output logic [31:0]        pix_data_o,
  output logic               pix_last_o,
  input  logic               pix_ready_i,
  output logic               busy_o,
  output logic               overrun_o
);
  localparam int unsigned CNT_W = 2*COORD_W + 4;

  logic               go, start_ok;
  logic [1:0]         lg_d, lg_q;
  logic [SUB_W-1:0]   pwm1_d, pwm1_q;
  logic [CNT_W-1:0]   words_d, pix_d;
  logic               mono_q;
  logic [DATA_W-1:0]  fg_q, bg_q;
  logic               words_pend, pix_pend, pix_one;
  logic               take, load_hold, hold_free, pix_fire, ovr_q;

  hdp_cmd_decode #(.COORD_W(COORD_W), .CNT_W(CNT_W)) u_dec (
    .host_src_i   (cmd_host_src_i),
    .mono_i       (cmd_mono_i),
    .fill_i       (cmd_fill_i),
    .depth_sel_i  (depth_sel_i),
    .width_m1_i   (width_m1_i),
    .height_m1_i  (height_m1_i),
    .go_o         (go),
    .lg_o         (lg_d),
    .per_word_m1_o(pwm1_d),
    .words_o      (words_d),
    .pix_o        (pix_d)
  );

  assign start_ok = cmd_start_i & go & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mono_q <= 1'b0;
      lg_q   <= '0;
      pwm1_q <= '0;
      fg_q   <= '0;
      bg_q   <= '0;
    end else if (start_ok) begin
      mono_q <= cmd_mono_i;
      lg_q   <= lg_d;
      pwm1_q <= pwm1_d;
      fg_q   <= fg_color_i;
      bg_q   <= bg_color_i;
    end
  end

  hdp_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start_ok),
    .words_i     (words_d),
    .pix_i       (pix_d),
    .word_take_i (take),
    .pix_fire_i  (pix_fire),
    .words_pend_o(words_pend),
    .pix_pend_o  (pix_pend),
    .pix_one_o   (pix_one),
    .busy_o      (busy_o)
  );

  // idle: swallow; busy: accept when the holding word is empty or leaving
  assign hw_ready_o = ~busy_o | (words_pend & (~pix_valid_o | hold_free));
  assign take       = hw_valid_i & hw_ready_o & busy_o;
  assign pix_fire   = pix_valid_o & pix_ready_i;
  // a word arriving after the final pixel is counted but dropped
  assign load_hold  = take & pix_pend & ~(pix_fire & pix_one);

  hdp_unpack u_unp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_hold),
    .word_i       (hw_data_i),
    .mono_i       (mono_q),
    .lg_i         (lg_q),
    .per_word_m1_i(pwm1_q),
    .fg_i         (fg_q),
    .bg_i         (bg_q),
    .last_pix_i   (pix_one),
    .pix_ready_i  (pix_ready_i),
    .pix_valid_o  (pix_valid_o),
    .pix_data_o   (pix_data_o),
    .free_o       (hold_free)
  );

  assign pix_last_o = pix_valid_o & pix_one;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovr_q <= 1'b0;
    else         ovr_q <= hw_valid_i & hw_ready_o & ~busy_o;
  end
  assign overrun_o = ovr_q;
endmodule

// File: rtl/hdp_checker.sv
module hdp_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        pix_valid_o,
  input logic [31:0] pix_data_o,
  input logic        pix_last_o,
  input logic        pix_ready_i,
  input logic        hw_valid_i,
  input logic        hw_ready_o,
  input logic        overrun_o
);
  a_r1_no_pix_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !pix_valid_o);
  a_r7_idle_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> hw_ready_o);
  a_r7_overrun_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_valid_i && hw_ready_o && !busy_o) |=> overrun_o);
  a_r7_overrun_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_valid_i || busy_o) |=> !overrun_o);
  a_r9_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !pix_ready_i) |=> (pix_valid_o && $stable(pix_data_o)));
  a_r9_last_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_last_o |-> pix_valid_o);
endmodule

bind hostdata_port hdp_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .pix_valid_o(pix_valid_o),
  .pix_data_o (pix_data_o),
  .pix_last_o (pix_last_o),
  .pix_ready_i(pix_ready_i),
  .hw_valid_i (hw_valid_i),
  .hw_ready_o (hw_ready_o),
  .overrun_o  (overrun_o)
);

// File: tb/hostdata_port_tb_top.sv
`timescale 1ns/1ps
module hostdata_port_tb_top;
  localparam int COORD_W = 12;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cmd_start_i = 0, cmd_host_src_i = 0, cmd_mono_i = 0, cmd_fill_i = 0;
  logic [1:0] depth_sel_i = 0;
  logic [COORD_W-1:0] width_m1_i = 0, height_m1_i = 0;
  logic [31:0] fg_color_i = 0, bg_color_i = 0, hw_data_i = 0;
  logic hw_valid_i = 0, pix_ready_i = 0;
  logic hw_ready_o, pix_valid_o, pix_last_o, busy_o, overrun_o;
  logic [31:0] pix_data_o;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] words [0:255];
  logic t_mono; int t_lg; logic [31:0] t_fg, t_bg;

  always #10 clk_i = ~clk_i;

  hostdata_port #(.COORD_W(COORD_W)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] exp_pix(input int k);
    logic [31:0] m, w;
    int s, ppw;
    m = (t_lg == 0) ? 32'hFF : (t_lg == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    if (t_mono) begin
      w = words[k/32];
      s = k % 32;
      return (w[(s/8)*8 + 7 - (s%8)] ? t_fg : t_bg) & m;
    end
    ppw = 4 >> t_lg;
    w = words[k/ppw];
    return (w >> ((k % ppw) * (8 << t_lg))) & m;
  endfunction

  task automatic send_idle_word(input string req);
    @(negedge clk_i);
    hw_valid_i = 1; hw_data_i = $urandom;
    #1 chk(hw_ready_o === 1'b1, "R7 idle ready", {31'b0, hw_ready_o}, 32'd1);
    @(negedge clk_i);
    hw_valid_i = 0;
    chk(overrun_o === 1'b1, req, {31'b0, overrun_o}, 32'd1);
    @(negedge clk_i);
    chk(overrun_o === 1'b0, "R7 pulse width", {31'b0, overrun_o}, 32'd0);
  endtask

  task automatic run_cmd(input logic mono, input int dsel, input int w, input int h, input bit restart);
    int n, nw, wi, pk, cyc;
    bit bad_order;
    t_mono = mono;
    t_lg = (dsel == 0) ? 0 : (dsel == 1) ? 1 : 2;
    t_fg = $urandom; t_bg = $urandom;
    n  = w * h;
    nw = (n * (mono ? 1 : (1 << t_lg)) + 3) / 4;
    for (int i = 0; i < nw; i++) words[i] = $urandom;
    @(negedge clk_i);
    cmd_start_i = 1; cmd_host_src_i = 1; cmd_fill_i = 0; cmd_mono_i = mono;
    depth_sel_i = dsel[1:0]; width_m1_i = COORD_W'(w - 1); height_m1_i = COORD_W'(h - 1);
    fg_color_i = t_fg; bg_color_i = t_bg;
    @(negedge clk_i);
    cmd_start_i = 0; fg_color_i = ~t_fg;
    chk(busy_o === 1'b1, "R1 busy after start", {31'b0, busy_o}, 32'd1);
    wi = 0; pk = 0; cyc = 0; bad_order = 0;
    while ((wi < nw || pk < n) && cyc < 20000) begin
      hw_valid_i  = (wi < nw) && ($urandom % 4 != 0);
      hw_data_i   = (wi < nw) ? words[wi] : 32'h0;
      pix_ready_i = ($urandom % 4 != 0);
      if (restart && cyc == 2) begin
        cmd_start_i = 1; width_m1_i = width_m1_i ^ 1; cmd_mono_i = ~mono;
      end else cmd_start_i = 0;
      #1;
      if (pix_valid_o && pix_ready_i) begin
        if (pk >= n) chk(0, "R8 extra pixel", pix_data_o, 32'h0);
        else begin
          chk(pix_data_o === exp_pix(pk), mono ? "R5 mono pixel" : "R4 colour pixel", pix_data_o, exp_pix(pk));
          if (pix_last_o !== (pk == n - 1)) begin
            chk(0, "R9 last flag", {31'b0, pix_last_o}, {31'b0, pk == n - 1});
          end
        end
        pk++;
      end
      if (hw_valid_i && hw_ready_o) wi++;
      @(negedge clk_i);
      cyc++;
    end
    hw_valid_i = 0; pix_ready_i = 0; cmd_start_i = 0;
    chk(pk == n, "R4 pixel count", pk, n);
    chk(wi == nw, mono ? "R6 mono word budget" : "R3 word budget", wi, nw);
    chk(busy_o === 1'b0, "R1 idle at end", {31'b0, busy_o}, 32'd0);
    send_idle_word("R3 exact count then overrun");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(busy_o === 1'b0 && pix_valid_o === 1'b0 && overrun_o === 1'b0 && hw_ready_o === 1'b1,
        "R10 reset state", {28'b0, busy_o, pix_valid_o, overrun_o, hw_ready_o}, 32'h1);
    rst_ni = 1;
    void'($urandom(32'd1234));
    @(negedge clk_i);
    // R2: fill and memory-sourced starts do nothing
    cmd_start_i = 1; cmd_host_src_i = 1; cmd_fill_i = 1; width_m1_i = 3; height_m1_i = 3;
    @(negedge clk_i);
    cmd_start_i = 0;
    chk(busy_o === 1'b0, "R2 fill ignored", {31'b0, busy_o}, 32'd0);
    cmd_start_i = 1; cmd_host_src_i = 0; cmd_fill_i = 0;
    @(negedge clk_i);
    cmd_start_i = 0;
    chk(busy_o === 1'b0 && pix_valid_o === 1'b0, "R2 non-host ignored", {31'b0, busy_o}, 32'd0);
    send_idle_word("R7 idle overrun");
    // directed corners
    run_cmd(0, 0, 1, 1, 0);
    run_cmd(1, 0, 1, 1, 0);
    run_cmd(1, 1, 40, 3, 0);
    run_cmd(0, 2, 7, 5, 1);
    run_cmd(1, 3, 33, 1, 1);
    run_cmd(0, 1, 3, 3, 0);
    run_cmd(0, 3, 2, 2, 0);
    for (int t = 0; t < 60; t++)
      run_cmd($urandom % 2, $urandom % 4, 1 + $urandom % 9, 1 + $urandom % 9, ($urandom % 4) == 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule